// File: doc/BRIEF.md
# Error Event Counter Bank with Sticky Overflow Status

This block keeps a bank of independent 8-bit counters for line maintenance monitoring. Each counter has its own single-cycle event input and counts one for every pulse. When a counter rolls over from 255 to 0, a bit is set in a shared sticky overflow register. That bit means 256 more errors have arrived since the previous rollover.

A processor reaches the bank through a simple synchronous register port. It can preset any counter, mask the interrupt sources, and collect event and overflow status. A control bit clears every counter and keeps it at zero while the bit is set. A second control bit selects sample mode. In sample mode the counts that software reads change only on an external one-second tick, and the live counters start again from zero on each tick.

Top module: `err_cnt_bank`

## Requirements
- R1: After reset every register reads 0. Each pulse on `evt_i[i]` adds one to counter i. Counter i is read at address i (0..NUM_CNT-1). `rdata_o` is valid in the cycle after `rd_en_i` is accepted.
- R2: An event that arrives when counter i holds 255 wraps the counter to 0. In the same edge it sets bit i of the overflow register.
- R3: The overflow register is at address NUM_CNT+4, with bit i belonging to counter i. A bit stays set until the register is read. A read returns the current bits and clears them. If an overflow happens in the same cycle as the read, the new bit is set after the read.
- R4: Control register bit 0 (address NUM_CNT) is the clear-and-hold bit. While it is 1, every live counter and every sample holding register is 0, and events and counter writes have no effect on them.
- R5: Writing address i presets live counter i to the written byte. A write in the same cycle as an event or a tick takes priority over them.
- R6: The event flag register is at address NUM_CNT+3. Bit i is set by any pulse on `evt_i[i]`. Writing a 1 to a bit clears that bit. A pulse in the same cycle as the write keeps its bit set.
- R7: `irq_o` = OR of (event flags AND event mask) OR (overflow bits AND overflow mask). The event mask is at address NUM_CNT+1 and the overflow mask is at address NUM_CNT+2, with bit i belonging to counter i.
- R8: Control bit 1 selects sample mode. In this mode, a read of address i returns a holding register. On each `tick_i` the holding register takes the live count, and the live counter restarts at 0, or at 1 if an event comes in the same cycle. Between ticks the returned values do not change.
- R9: The control register and both mask registers read back what was written. Unused bits read 0, and addresses above NUM_CNT+4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_CNT | Per-counter error event pulses |
| tick_i | input | 1 | One-second sample tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data, registered |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that reads and writes are never strobed in the same cycle. Under that assumption, every read of the overflow register returns exactly the bits held before the read. The bench keeps the two strobes exclusive in both its directed and its random phases. It makes ticks short pulses at a low rate and turns on the clear-and-hold bit only some of the time, so counters can still reach rollover. Event pulses are unconstrained, including in the cycles where a counter is at 255 while the overflow register is being read.

// File: rtl/err_cnt_bank.sv
module err_cnt_bank #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W = 8,
  localparam int AW = $clog2(NUM_CNT + 5)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam logic [AW-1:0] A_CTL = AW'(NUM_CNT);
  localparam logic [AW-1:0] A_EVM = AW'(NUM_CNT + 1);
  localparam logic [AW-1:0] A_OVM = AW'(NUM_CNT + 2);
  localparam logic [AW-1:0] A_EVF = AW'(NUM_CNT + 3);
  localparam logic [AW-1:0] A_OVF = AW'(NUM_CNT + 4);

  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q, hold_q;
  logic [1:0]         ctl_q;
  logic [NUM_CNT-1:0] evm_q, ovm_q, evf_q, ovf_q, ovf_set;
  logic [CNT_W-1:0]   rd_mux;

  wire clr      = ctl_q[0];
  wire smode    = ctl_q[1];
  wire smp_tick = smode & tick_i;
  wire rd_ovf   = rd_en_i && addr_i == A_OVF;
  wire wr_evf   = wr_en_i && addr_i == A_EVF;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    wire wr_hit = wr_en_i && addr_i == AW'(i);
    assign ovf_set[i] = !clr && !wr_hit && !smp_tick && evt_i[i] && (&cnt_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i]  <= '0;
        hold_q[i] <= '0;
      end else begin
        if (clr)            cnt_q[i] <= '0;
        else if (wr_hit)    cnt_q[i] <= wdata_i;
        else if (smp_tick)  cnt_q[i] <= CNT_W'(evt_i[i]);
        else if (evt_i[i])  cnt_q[i] <= cnt_q[i] + CNT_W'(1);
        if (clr)            hold_q[i] <= '0;
        else if (smp_tick)  hold_q[i] <= cnt_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      evm_q <= '0;
      ovm_q <= '0;
      evf_q <= '0;
      ovf_q <= '0;
    end else begin
      if (wr_en_i && addr_i == A_CTL) ctl_q <= wdata_i[1:0];
      if (wr_en_i && addr_i == A_EVM) evm_q <= wdata_i[NUM_CNT-1:0];
      if (wr_en_i && addr_i == A_OVM) ovm_q <= wdata_i[NUM_CNT-1:0];
      evf_q <= (evf_q & ~(wr_evf ? wdata_i[NUM_CNT-1:0] : '0)) | evt_i;
      ovf_q <= (rd_ovf ? '0 : ovf_q) | ovf_set;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (addr_i == AW'(i)) rd_mux = smode ? hold_q[i] : cnt_q[i];
    if (addr_i == A_CTL) rd_mux = CNT_W'(ctl_q);
    if (addr_i == A_EVM) rd_mux = CNT_W'(evm_q);
    if (addr_i == A_OVM) rd_mux = CNT_W'(ovm_q);
    if (addr_i == A_EVF) rd_mux = CNT_W'(evf_q);
    if (addr_i == A_OVF) rd_mux = CNT_W'(ovf_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign irq_o = |(evf_q & evm_q) | |(ovf_q & ovm_q);
endmodule

module err_cnt_bank_chk #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W = 8,
  parameter int AW = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CNT-1:0]            evt_i,
  input logic                          tick_i,
  input logic                          wr_en_i,
  input logic                          rd_en_i,
  input logic [AW-1:0]                 addr_i,
  input logic [CNT_W-1:0]              rdata_o,
  input logic                          irq_o,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0] hold_q,
  input logic [1:0]                    ctl_q,
  input logic [NUM_CNT-1:0]            evm_q,
  input logic [NUM_CNT-1:0]            ovm_q,
  input logic [NUM_CNT-1:0]            ovf_q
);
  localparam logic [AW-1:0] A_OVF = AW'(NUM_CNT + 4);

  // R4
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0] |=> (cnt_q == '0 && hold_q == '0));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evm_q == '0 && ovm_q == '0) |-> !irq_o);

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && addr_i == A_OVF) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R3
  ovf_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && addr_i == A_OVF) |=> rdata_o == CNT_W'($past(ovf_q)));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ctl_q[0]) |=> $stable(hold_q));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_wrap
    // R2
    wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[0] && !(wr_en_i && addr_i == AW'(i)) && !(ctl_q[1] && tick_i)
       && evt_i[i] && cnt_q[i] == '1) |=> (cnt_q[i] == '0 && ovf_q[i]));
  end
endmodule

bind err_cnt_bank err_cnt_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .AW(AW)) u_chk (.*);

// File: tb/test_err_cnt_bank.sv
module test_err_cnt_bank;
  localparam int N = 4;
  localparam int AW = $clog2(N + 5);
  localparam int CLK_PERIOD = 10;
  localparam int A_CTL = N, A_EVM = N + 1, A_OVM = N + 2, A_EVF = N + 3, A_OVF = N + 4;

  logic clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [N-1:0] evt = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int vectors = 0, fails = 0;

  logic [7:0] m_cnt [N];
  logic [7:0] m_hold [N];
  logic [1:0] m_ctl = '0;
  logic [N-1:0] m_evm = '0, m_ovm = '0, m_evf = '0, m_ovf = '0;

  err_cnt_bank #(.NUM_CNT(N), .CNT_W(8)) i_err_cnt_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .tick_i(tick), .wr_en_i(wr),
    .rd_en_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] model_read(input int a);
    if (a < N) return m_ctl[1] ? m_hold[a] : m_cnt[a];
    if (a == A_CTL) return {6'b0, m_ctl};
    if (a == A_EVM) return 8'(m_evm);
    if (a == A_OVM) return 8'(m_ovm);
    if (a == A_EVF) return 8'(m_evf);
    if (a == A_OVF) return 8'(m_ovf);
    return 8'h00;
  endfunction

  function automatic logic model_irq();
    return |(m_evf & m_evm) | |(m_ovf & m_ovm);
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_step(input logic [N-1:0] e, input logic t, input logic w,
                            input logic r, input int a, input logic [7:0] d);
    logic [N-1:0] set = '0;
    for (int i = 0; i < N; i++) begin
      if (m_ctl[0]) begin
        m_cnt[i] = 0; m_hold[i] = 0;
      end else begin
        if (m_ctl[1] && t) m_hold[i] = m_cnt[i];
        if (w && a == i) m_cnt[i] = d;
        else if (m_ctl[1] && t) m_cnt[i] = {7'b0, e[i]};
        else if (e[i]) begin
          if (m_cnt[i] == 8'hff) set[i] = 1'b1;
          m_cnt[i] = m_cnt[i] + 8'd1;
        end
      end
    end
    m_evf = (m_evf & ~((w && a == A_EVF) ? d[N-1:0] : '0)) | e;
    m_ovf = ((r && a == A_OVF) ? '0 : m_ovf) | set;
    if (w && a == A_CTL) m_ctl = d[1:0];
    if (w && a == A_EVM) m_evm = d[N-1:0];
    if (w && a == A_OVM) m_ovm = d[N-1:0];
  endtask

  task automatic apply(input logic [N-1:0] e, input logic t, input logic w, input logic r,
                       input int a, input logic [7:0] d, input string req);
    logic [7:0] exp;
    @(negedge clk);
    evt = e; tick = t; wr = w; rd = r; addr = AW'(a); wdata = d;
    exp = model_read(a);
    @(posedge clk);
    model_step(e, t, w, r, a, d);
    #1;
    if (r) check(rdata, exp, req);
    check({7'b0, irq}, {7'b0, model_irq()}, "R7");
    evt = '0; tick = 0; wr = 0; rd = 0;
  endtask

  task automatic rd_reg(input int a, input string req);
    apply('0, 0, 0, 1, a, 8'h00, req);
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    apply('0, 0, 1, 0, a, d, "R5");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0b1c));
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_hold[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 R9 reset state, unmapped addresses
    for (int a = 0; a < (1 << AW); a++) rd_reg(a, a > A_OVF ? "R9" : "R1");

    // R1 counting on several patterns
    repeat (5) apply(4'b0001, 0, 0, 0, 0, 0, "R1");
    repeat (3) apply(4'b1010, 0, 0, 0, 0, 0, "R1");
    rd_reg(0, "R1"); rd_reg(1, "R1"); rd_reg(3, "R1");

    // R5 preset, R2 wrap, R3 read clears
    wr_reg(1, 8'd254);
    apply(4'b0010, 0, 0, 0, 0, 0, "R2");
    apply(4'b0010, 0, 0, 0, 0, 0, "R2");
    rd_reg(1, "R2");
    rd_reg(A_OVF, "R3"); rd_reg(A_OVF, "R3");

    // R3 overflow in the same cycle as the clearing read
    wr_reg(2, 8'd255);
    apply(4'b0100, 0, 0, 1, A_OVF, 0, "R3");
    rd_reg(A_OVF, "R3"); rd_reg(2, "R2");

    // R5 write beats coincident event
    apply(4'b0001, 0, 1, 0, 0, 8'd40, "R5");
    rd_reg(0, "R5");

    // R4 clear-and-hold
    wr_reg(A_CTL, 8'h01);
    repeat (3) apply(4'b1111, 0, 0, 0, 0, 0, "R4");
    wr_reg(0, 8'd7);
    rd_reg(0, "R4"); rd_reg(3, "R4");
    wr_reg(A_CTL, 8'h00);
    rd_reg(A_CTL, "R9");

    // R6 R7 flags, masks and interrupt
    wr_reg(A_EVF, 8'h0f);
    wr_reg(A_EVM, 8'h01); rd_reg(A_EVM, "R9");
    apply(4'b0001, 0, 0, 0, 0, 0, "R7");
    rd_reg(A_EVF, "R6");
    apply(4'b0001, 0, 1, 0, A_EVF, 8'h01, "R6");
    rd_reg(A_EVF, "R6");
    wr_reg(A_EVF, 8'h01);
    rd_reg(A_EVF, "R6");
    wr_reg(3, 8'hff); wr_reg(A_OVM, 8'h08);
    apply(4'b1000, 0, 0, 0, 0, 0, "R7");
    rd_reg(A_OVF, "R3");

    // R8 sample mode
    wr_reg(A_CTL, 8'h02);
    repeat (3) apply(4'b1000, 0, 0, 0, 0, 0, "R8");
    rd_reg(3, "R8");
    apply(4'b1000, 1, 0, 0, 0, 0, "R8");
    rd_reg(3, "R8");
    repeat (4) apply(4'b1000, 0, 0, 0, 0, 0, "R8");
    rd_reg(3, "R8");
    apply(4'b0000, 1, 1, 0, 3, 8'd9, "R8");
    rd_reg(3, "R8");
    apply(4'b0000, 1, 0, 0, 0, 0, "R8");
    rd_reg(3, "R8");
    wr_reg(A_CTL, 8'h00);

    // random mix across all requirements
    for (int k = 0; k < 6000; k++) begin
      logic [N-1:0] e;
      int a, sel;
      logic [7:0] d;
      for (int i = 0; i < N; i++) e[i] = ($urandom % 3) == 0;
      a = $urandom % (1 << AW);
      d = 8'($urandom);
      sel = $urandom % 16;
      if (a == A_CTL) d = {6'b0, 1'($urandom % 2), ($urandom % 6) == 0};
      if (sel == 0)
        apply(e, ($urandom % 50) == 0, 1, 0, a, d, "R5");
      else if (sel < 6)
        apply(e, ($urandom % 50) == 0, 0, 1, a, 0, a < N ? "R1" : "R3");
      else
        apply(e, ($urandom % 50) == 0, 0, 0, 0, 0, "R8");
    end
    for (int a = 0; a <= A_OVF; a++) rd_reg(a, "R9");
    finish_run();
  end
endmodule